// File: doc/BRIEF.md
# Pass-Through Register Programming Sequencer

This block lets a host load a local DMA engine's address and transfer count registers through a bridge chip's pass-through port, with no local processor involved. An active-low attention strobe from the bridge starts a fixed four-state handshake: idle, address, then two strobe states. In the address state the block drives its address strobe and decodes a region number. In both strobe states it drives the read strobe and the ready strobe together. The 32-bit word on the data bus is then captured into the selected register, or thrown away when the region selects no target.

The block also keeps the DMA master's start logic and the register access mutually exclusive. The sequencer leaves idle only while no transfer is running. The master may start a transfer only while the sequencer is idle and no attention strobe is pending, so a pass-through access wins a tie. The busy flag tells the master that a register access is in progress.

Top module: `ptprog_top`

## Requirements
- R1: While reset is high and after it is released, the sequencer is idle, and adr_n, rd_n and rdy_n are high. busy, dma_start and dma_run are low, and both registers hold zero.
- R2: In idle, the sequencer goes to the address state on the clock edge where attn_n is low and dma_run is low. While dma_run is high, a low attn_n is held off until dma_run falls.
- R3: adr_n is low for exactly one cycle, starting one edge after the request is accepted. rd_n and rdy_n are high during that cycle.
- R4: For exactly the two cycles after the address cycle, rd_n and rdy_n are both low and adr_n is high.
- R5: After the second strobe cycle, the sequencer returns to idle whatever the inputs are. All three strobes go high again and busy goes low.
- R6: The region number is sampled during the address cycle. Code 0 selects the address register and code 1 selects the count register. data_in is sampled on the edge that ends the second strobe cycle and appears in the selected register from that edge on.
- R7: Region codes 2 and 3 run the full strobe sequence but leave both registers unchanged.
- R8: busy is high for exactly the three cycles of the address and strobe states, and low otherwise.
- R9: A dma_req is granted, as a one-cycle dma_start pulse one edge later, only when busy is low, attn_n is high and dma_run is low. When dma_req and attn_n are asserted on the same edge, the register access goes first.
- R10: dma_run is set on the edge that raises dma_start and cleared on the edge where dma_done is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_n | input | 1 | Pass-through attention strobe, active low |
| region | input | 2 | Pass-through region number |
| data_in | input | 32 | Pass-through data word |
| dma_req | input | 1 | DMA master asks to start a transfer |
| dma_done | input | 1 | DMA engine reports end of transfer |
| adr_n | output | 1 | Address strobe, active low |
| rd_n | output | 1 | Read strobe to the bridge, active low |
| rdy_n | output | 1 | Access-complete ready strobe, active low |
| busy | output | 1 | Register access in progress |
| dma_start | output | 1 | One-cycle start grant to the DMA engine |
| dma_run | output | 1 | DMA transfer in progress |
| dma_addr | output | 32 | DMA address register |
| dma_count | output | 32 | DMA transfer count register |

## Verification
Writes are issued with all four region codes and with data words of all ones, zero and mixed patterns. This separates a correct register selection from a swapped one, and a no-target access that is dropped from one that leaks into a register. Each write checks the strobe waveform cycle by cycle, so a stretched or shifted strobe is caught. A request made while a transfer runs shows whether the hold-off lasts exactly until dma_done. A request made on the same edge as dma_req shows which side wins the tie, and that the master is granted only after the sequencer is back in idle.

// File: rtl/ptprog_pkg.sv
package ptprog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STB1 = 2'd2,
    ST_STB2 = 2'd3
  } seq_st_t;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_ADDR  = 2'd1,
    TGT_COUNT = 2'd2
  } tgt_t;
endpackage

// File: rtl/ptprog_seq.sv
module ptprog_seq
  import ptprog_pkg::*;
#(
  parameter int REGION_W     = 2,
  parameter int ADDR_REGION  = 0,
  parameter int COUNT_REGION = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                attn_n,
  input  logic                dma_run,
  input  logic [REGION_W-1:0] region,
  output logic                adr_n,
  output logic                rd_n,
  output logic                rdy_n,
  output logic                busy,
  output logic                commit,
  output tgt_t                tgt
);
  seq_st_t st_q, st_d;
  tgt_t    tgt_q;

  function automatic tgt_t decode(input logic [REGION_W-1:0] r);
    if (r == REGION_W'(ADDR_REGION))       return TGT_ADDR;
    else if (r == REGION_W'(COUNT_REGION)) return TGT_COUNT;
    else                                   return TGT_NONE;
  endfunction

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (!attn_n && !dma_run) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_STB1;
      ST_STB1: st_d = ST_STB2;
      ST_STB2: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      tgt_q <= TGT_NONE;
      adr_n <= 1'b1;
      rd_n  <= 1'b1;
      rdy_n <= 1'b1;
      busy  <= 1'b0;
    end else begin
      st_q  <= st_d;
      if (st_q == ST_ADDR) tgt_q <= decode(region);
      adr_n <= !(st_d == ST_ADDR);
      rd_n  <= !(st_d == ST_STB1 || st_d == ST_STB2);
      rdy_n <= !(st_d == ST_STB1 || st_d == ST_STB2);
      busy  <= (st_d != ST_IDLE);
    end
  end

  assign commit = (st_q == ST_STB2);
  assign tgt    = tgt_q;
endmodule

// File: rtl/ptprog_regs.sv
module ptprog_regs
  import ptprog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  tgt_t              tgt,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      count_q <= '0;
    end else if (commit) begin
      case (tgt)
        TGT_ADDR:  addr_q  <= data_in;
        TGT_COUNT: count_q <= data_in;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/ptprog_gate.sv
module ptprog_gate (
  input  logic clk,
  input  logic rst,
  input  logic dma_req,
  input  logic dma_done,
  input  logic busy,
  input  logic attn_n,
  output logic dma_start,
  output logic dma_run
);
  logic start_ok;

  assign start_ok = dma_req && !dma_run && !busy && attn_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_start <= 1'b0;
      dma_run   <= 1'b0;
    end else begin
      dma_start <= start_ok;
      if (start_ok)      dma_run <= 1'b1;
      else if (dma_done) dma_run <= 1'b0;
    end
  end
endmodule

// File: rtl/ptprog_top.sv
module ptprog_top
  import ptprog_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int REGION_W     = 2,
  parameter int ADDR_REGION  = 0,
  parameter int COUNT_REGION = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                attn_n,
  input  logic [REGION_W-1:0] region,
  input  logic [DATA_W-1:0]   data_in,
  input  logic                dma_req,
  input  logic                dma_done,
  output logic                adr_n,
  output logic                rd_n,
  output logic                rdy_n,
  output logic                busy,
  output logic                dma_start,
  output logic                dma_run,
  output logic [DATA_W-1:0]   dma_addr,
  output logic [DATA_W-1:0]   dma_count
);
  logic commit;
  tgt_t tgt;

  ptprog_seq #(
    .REGION_W    (REGION_W),
    .ADDR_REGION (ADDR_REGION),
    .COUNT_REGION(COUNT_REGION)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .attn_n (attn_n),
    .dma_run(dma_run),
    .region (region),
    .adr_n  (adr_n),
    .rd_n   (rd_n),
    .rdy_n  (rdy_n),
    .busy   (busy),
    .commit (commit),
    .tgt    (tgt)
  );

  ptprog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .tgt    (tgt),
    .data_in(data_in),
    .addr_q (dma_addr),
    .count_q(dma_count)
  );

  ptprog_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .dma_req  (dma_req),
    .dma_done (dma_done),
    .busy     (busy),
    .attn_n   (attn_n),
    .dma_start(dma_start),
    .dma_run  (dma_run)
  );
endmodule

// File: rtl/ptprog_chk.sv
module ptprog_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              attn_n,
  input logic              dma_done,
  input logic              adr_n,
  input logic              rd_n,
  input logic              rdy_n,
  input logic              busy,
  input logic              dma_start,
  input logic              dma_run,
  input logic [DATA_W-1:0] dma_addr,
  input logic [DATA_W-1:0] dma_count
);
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(!attn_n) && $past(!dma_run)));

  p_addr_then_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !adr_n |-> (busy && rd_n && rdy_n));

  p_strobe_follows_r4: assert property (@(posedge clk) disable iff (rst)
    !adr_n |=> (!rd_n && !rdy_n && adr_n));

  p_strobes_paired_r4: assert property (@(posedge clk) disable iff (rst)
    rd_n == rdy_n);

  p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  p_regs_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> ($stable(dma_addr) && $stable(dma_count)));

  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !(dma_start && busy));

  p_start_sets_run_r10: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> dma_run);

  p_done_clears_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(dma_done) && !dma_start) |-> !dma_run);
endmodule

bind ptprog_top ptprog_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .attn_n   (attn_n),
  .dma_done (dma_done),
  .adr_n    (adr_n),
  .rd_n     (rd_n),
  .rdy_n    (rdy_n),
  .busy     (busy),
  .dma_start(dma_start),
  .dma_run  (dma_run),
  .dma_addr (dma_addr),
  .dma_count(dma_count)
);

// File: tb/sim_ptprog_top.sv
`timescale 1ns/1ps
module sim_ptprog_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        attn_n = 1'b1;
  logic [1:0]  region = 2'd0;
  logic [31:0] data_in = '0;
  logic        dma_req = 1'b0;
  logic        dma_done = 1'b0;
  logic        adr_n, rd_n, rdy_n, busy, dma_start, dma_run;
  logic [31:0] dma_addr, dma_count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] count;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [31:0] m_addr = '0;
  logic [31:0] m_count = '0;

  always #2 clk = ~clk;

  ptprog_top u0 (
    .clk(clk), .rst(rst), .attn_n(attn_n), .region(region), .data_in(data_in),
    .dma_req(dma_req), .dma_done(dma_done), .adr_n(adr_n), .rd_n(rd_n),
    .rdy_n(rdy_n), .busy(busy), .dma_start(dma_start), .dma_run(dma_run),
    .dma_addr(dma_addr), .dma_count(dma_count)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // strobes {adr_n,rd_n,rdy_n,busy}
  task automatic chk_pins(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {adr_n, rd_n, rdy_n, busy};
    chk(act == exp, tag, 32'(act), 32'(exp));
  endtask

  // called at the negedge where the address cycle is visible
  task automatic finish_seq(input logic [1:0] rg, input logic [31:0] d);
    exp_t e;
    chk_pins(4'b0111, "R3 address cycle");
    attn_n = 1'b1;
    @(negedge clk) chk_pins(4'b1001, "R4 first strobe");
    @(negedge clk) chk_pins(4'b1001, "R4 second strobe");
    if (rg == 2'd0) m_addr = d;
    else if (rg == 2'd1) m_count = d;
    e.addr = m_addr; e.count = m_count;
    e.tag = (rg > 2'd1) ? "R7" : "R6";
    sb.push_back(e);
    @(negedge clk) chk_pins(4'b1110, "R5 back to idle");
  endtask

  task automatic pt_write(input logic [1:0] rg, input logic [31:0] d);
    @(negedge clk);
    attn_n = 1'b0; region = rg; data_in = d;
    @(negedge clk);
    finish_seq(rg, d);
  endtask

  // scoreboard monitor: compare when ready strobe is released
  initial begin
    logic prev_rdy;
    prev_rdy = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst && !prev_rdy && rdy_n) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected write", 32'(dma_addr), 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(dma_addr == e.addr, {e.tag, " address register"}, dma_addr, e.addr);
          chk(dma_count == e.count, {e.tag, " count register"}, dma_count, e.count);
        end
      end
      prev_rdy = rdy_n;
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_pins(4'b1110, "R1 reset strobes");
    chk({dma_start, dma_run} == 2'b00, "R1 reset gate", 32'({dma_start, dma_run}), 32'h0);
    chk(dma_addr == 0 && dma_count == 0, "R1 reset regs", dma_addr | dma_count, 32'h0);
    rst = 1'b0;
    @(negedge clk) chk_pins(4'b1110, "R1 idle after release");

    pt_write(2'd0, 32'hA5A5_0001);
    pt_write(2'd1, 32'h0000_0100);
    pt_write(2'd2, 32'hDEAD_BEEF);
    pt_write(2'd3, 32'h0000_1234);
    pt_write(2'd0, 32'hFFFF_FFFF);
    pt_write(2'd1, 32'h0000_0000);
    pt_write(2'd1, 32'h5A5A_C3C3);

    // R10 start a transfer, then R2 hold-off
    @(negedge clk) dma_req = 1'b1;
    @(negedge clk);
    chk(dma_start == 1'b1, "R10 start pulse", 32'(dma_start), 32'h1);
    chk(dma_run == 1'b1, "R10 run set", 32'(dma_run), 32'h1);
    dma_req = 1'b0;
    attn_n = 1'b0; region = 2'd0; data_in = 32'h0BAD_F00D;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) chk_pins(4'b1110, "R2 held off during transfer");
    end
    chk(dma_start == 1'b0, "R9 single start pulse", 32'(dma_start), 32'h0);
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    chk(dma_run == 1'b0, "R10 run cleared", 32'(dma_run), 32'h0);
    chk_pins(4'b1110, "R2 still idle on done edge");
    @(negedge clk);
    finish_seq(2'd0, 32'h0BAD_F00D);

    // R9 tie: access wins, master granted once idle
    @(negedge clk);
    dma_req = 1'b1; attn_n = 1'b0; region = 2'd1; data_in = 32'h0000_0777;
    @(negedge clk);
    chk(dma_start == 1'b0, "R9 tie goes to access", 32'(dma_start), 32'h0);
    finish_seq(2'd1, 32'h0000_0777);
    chk(dma_start == 1'b0, "R9 no start while busy", 32'(dma_start), 32'h0);
    @(negedge clk);
    chk(dma_start == 1'b1, "R9 start after idle", 32'(dma_start), 32'h1);
    dma_req = 1'b0;
    dma_done = 1'b1;
    @(negedge clk) dma_done = 1'b0;
    chk(dma_run == 1'b0, "R10 run cleared again", 32'(dma_run), 32'h0);

    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R6 all writes compared", 32'(sb.size()), 32'h0);
    finished = 1;
    summary();
  end
endmodule